// File: doc/BRIEF.md
# Debug Shadow Scan Chain

This block lets a debug host observe and override the registers of a small processor. The processor and the host run on clocks that have no fixed relation to each other. Seven shadow registers sit on one serial path clocked by the SPI clock:

- a control byte;
- shadows of the four general registers R0 to R3;
- a shadow of the program counter;
- a 16-bit shadow of the instruction register.

The control byte sits at the head of the path and drives MISO. The instruction shadow sits at the tail and takes in MOSI. On each rising edge of the SPI clock, every shadow shifts by one bit, unless a capture is pending. When a capture is pending, every shadow instead loads its live processor value, and the control byte reloads itself.

The capture pulse is made inside the block. It opens on a falling edge of the processor clock and closes on the next falling edge of the SPI clock. The host therefore waits for a processor-clock falling edge while the SPI clock idles low. It then gives one SPI clock to capture, followed by 64 SPI clocks for a full frame. During the frame, the captured state streams out on MISO while the replacement state streams in on MOSI.

The shadow values are offered to the processor as an alternate load source. The control byte provides three things to the processor:
- an instruction-bypass request;
- a decode-squelch request;
- four trigger lines.

It also provides the instruction-register load enable that follows from the two requests.

Top module: `dbg_scan_chain`

## Requirements
- R1: After a synchronous active-low reset (held for at least one edge of each clock), every shadow output and the control byte are zero, MISO is 0 and the instruction load enable is 1.
- R2: A processor-clock falling edge while the SPI clock is low makes the next SPI rising edge load every shadow with the live value of its processor register.
- R3: On that capture edge the control byte keeps its current value.
- R4: After a capture, MISO presents the frame before each of the next 64 SPI rising edges, most significant bit first, in this order: control byte, R0, R1, R2, R3, program counter, instruction shadow.
- R5: On a non-capture SPI rising edge, each shadow shifts one place towards MISO and takes its LSB from its neighbour on the MOSI side, with MOSI entering the instruction shadow LSB. After 64 shifts the chain holds exactly the 64 bits sent, the first bit sent ending in control bit 7.
- R6: Control bit 1 is the bypass request, control bit 2 is the squelch request, and control bits 7:4 are the trigger lines.
- R7: The instruction load enable is 1 exactly when bypass and squelch are equal.
- R8: A capture pulse serves a single SPI rising edge; an SPI rising edge with no processor-clock falling edge since the previous SPI falling edge shifts.
- R9: A processor-clock falling edge that occurs while the SPI clock is high is dropped at that SPI falling edge, so the following SPI rising edge shifts rather than captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_spi | input | 1 | Serial clock; shadows act on its rising edge |
| clk_cpu | input | 1 | Processor clock; its falling edge requests a capture |
| rst_n | input | 1 | Synchronous active-low reset for both clock domains |
| mosi | input | 1 | Serial data into the instruction shadow LSB |
| miso | output | 1 | Serial data from control bit 7 |
| cpu_r0 | input | 8 | Live R0 |
| cpu_r1 | input | 8 | Live R1 |
| cpu_r2 | input | 8 | Live R2 |
| cpu_r3 | input | 8 | Live R3 |
| cpu_pc | input | 8 | Live program counter |
| cpu_ir | input | 16 | Live instruction register |
| sh_r0 | output | 8 | R0 shadow |
| sh_r1 | output | 8 | R1 shadow |
| sh_r2 | output | 8 | R2 shadow |
| sh_r3 | output | 8 | R3 shadow |
| sh_pc | output | 8 | Program counter shadow |
| sh_ir | output | 16 | Instruction shadow |
| ctrl_q | output | 8 | Control byte |
| bypass_req | output | 1 | Instruction-bypass request |
| squelch_req | output | 1 | Decode-squelch request |
| trigger | output | 4 | Trigger lines |
| ir_load_en | output | 1 | Instruction register load enable |

## Verification
A broken link in the chain shows up on MISO within the same frame. Every bit is seen once, after a number of SPI clocks equal to its distance from the head. So a swapped or missing segment shifts every later field of the read frame.

A capture pulse that is wrong in either direction shows at the parallel outputs on the first SPI rising edge that follows:
- a lost capture gives shifted data;
- a capture that lasts too long freezes the chain or reloads live values.

A wrong control decode is visible on the request, trigger and load-enable outputs as soon as a frame completes.

// File: rtl/dbg_scan_pkg.sv
// Shared widths and control-byte field positions for the debug scan chain.
package dbg_scan_pkg;
    localparam int REG_W       = 8;   // general register and PC width
    localparam int IR_W        = 16;  // instruction register width
    localparam int NUM_GP      = 4;   // general registers R0..R3
    localparam int BYPASS_BIT  = 1;   // control bit: instruction bypass
    localparam int SQUELCH_BIT = 2;   // control bit: decode squelch
    localparam int TRIG_LO     = 4;   // control bits TRIG_LO+3..TRIG_LO: triggers
    localparam int TRIG_W      = 4;
endpackage

// File: rtl/dbg_scan_seg.sv
// One shadow segment of the scan chain.
// Loads par_in when load is high, otherwise shifts left taking si at the LSB.
// Assumes load is stable around the rising edge of clk.
module dbg_scan_seg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par_in,
    input  logic         si,
    output logic [W-1:0] q,
    output logic         so
);
    // Parallel load or one-bit shift per serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= par_in;
        else           q <= {q[W-2:0], si};
    end

    assign so = q[W-1];
endmodule

// File: rtl/dbg_capture_gen.sv
// Capture pulse generator crossing from the processor clock to the serial clock.
// The pulse opens on a falling edge of clk_cpu and closes on the next falling
// edge of clk_spi (a toggle request and its acknowledge).
// Assumes the serial clock idles low between transfers, so that the pulse
// covers the next rising edge of clk_spi.
module dbg_capture_gen (
    input  logic clk_cpu,
    input  logic clk_spi,
    input  logic rst_n,
    output logic cap
);
    logic req_q;
    logic ack_q;

    // Raise a request on a processor falling edge when none is pending.
    always_ff @(negedge clk_cpu) begin
        if (!rst_n)              req_q <= 1'b0;
        else if (req_q == ack_q) req_q <= ~req_q;
    end

    // Retire any open request on the serial falling edge.
    always_ff @(negedge clk_spi) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= req_q;
    end

    assign cap = req_q ^ ack_q;
endmodule

// File: rtl/dbg_scan_chain.sv
// Debug shadow scan chain: control byte at the MISO end, then R0..R3 and PC
// shadows, then the instruction shadow at the MOSI end.
// All shadows load live state on a capture pulse and shift otherwise.
// The control byte reloads itself on a capture and drives the override
// requests, the trigger lines and the instruction-register load enable.
module dbg_scan_chain
    import dbg_scan_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int IW = IR_W
) (
    input  logic          clk_spi,
    input  logic          clk_cpu,
    input  logic          rst_n,
    input  logic          mosi,
    output logic          miso,
    input  logic [RW-1:0] cpu_r0,
    input  logic [RW-1:0] cpu_r1,
    input  logic [RW-1:0] cpu_r2,
    input  logic [RW-1:0] cpu_r3,
    input  logic [RW-1:0] cpu_pc,
    input  logic [IW-1:0] cpu_ir,
    output logic [RW-1:0] sh_r0,
    output logic [RW-1:0] sh_r1,
    output logic [RW-1:0] sh_r2,
    output logic [RW-1:0] sh_r3,
    output logic [RW-1:0] sh_pc,
    output logic [IW-1:0] sh_ir,
    output logic [RW-1:0] ctrl_q,
    output logic          bypass_req,
    output logic          squelch_req,
    output logic [TRIG_W-1:0] trigger,
    output logic          ir_load_en
);
    logic              cap_pulse;
    logic [RW-1:0]     gp_live [NUM_GP];
    logic [RW-1:0]     gp_sh   [NUM_GP];
    logic [NUM_GP-1:0] gp_so;
    logic              pc_so;
    logic              ir_so;
    logic              ctrl_so;

    dbg_capture_gen u_cap (
        .clk_cpu (clk_cpu),
        .clk_spi (clk_spi),
        .rst_n   (rst_n),
        .cap     (cap_pulse)
    );

    assign gp_live[0] = cpu_r0;
    assign gp_live[1] = cpu_r1;
    assign gp_live[2] = cpu_r2;
    assign gp_live[3] = cpu_r3;

    // Head of chain: reloads its own value on capture.
    dbg_scan_seg #(.W(RW)) u_ctrl (
        .clk (clk_spi), .rst_n (rst_n), .load (cap_pulse),
        .par_in (ctrl_q), .si (gp_so[0]), .q (ctrl_q), .so (ctrl_so)
    );

    // General register shadows, R0 nearest the head.
    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        logic si_w;
        if (g == NUM_GP - 1) begin : g_last
            assign si_w = pc_so;
        end else begin : g_mid
            assign si_w = gp_so[g+1];
        end
        dbg_scan_seg #(.W(RW)) u_seg (
            .clk (clk_spi), .rst_n (rst_n), .load (cap_pulse),
            .par_in (gp_live[g]), .si (si_w), .q (gp_sh[g]), .so (gp_so[g])
        );
    end

    dbg_scan_seg #(.W(RW)) u_pc (
        .clk (clk_spi), .rst_n (rst_n), .load (cap_pulse),
        .par_in (cpu_pc), .si (ir_so), .q (sh_pc), .so (pc_so)
    );

    dbg_scan_seg #(.W(IW)) u_ir (
        .clk (clk_spi), .rst_n (rst_n), .load (cap_pulse),
        .par_in (cpu_ir), .si (mosi), .q (sh_ir), .so (ir_so)
    );

    assign sh_r0       = gp_sh[0];
    assign sh_r1       = gp_sh[1];
    assign sh_r2       = gp_sh[2];
    assign sh_r3       = gp_sh[3];
    assign miso        = ctrl_so;
    assign bypass_req  = ctrl_q[BYPASS_BIT];
    assign squelch_req = ctrl_q[SQUELCH_BIT];
    assign trigger     = ctrl_q[TRIG_LO +: TRIG_W];
    assign ir_load_en  = ~(bypass_req ^ squelch_req);
endmodule

// File: rtl/dbg_scan_chain_chk.sv
// Property checker for the debug scan chain, attached by bind.
// Assumes the serial clock edges are the only update points of the shadows.
module dbg_scan_chain_chk #(
    parameter int RW = 8,
    parameter int IW = 16
) (
    input logic          clk_spi,
    input logic          rst_n,
    input logic          cap,
    input logic          mosi,
    input logic [RW-1:0] ctrl_q,
    input logic [RW-1:0] sh_r0,
    input logic [RW-1:0] sh_pc,
    input logic [IW-1:0] sh_ir,
    input logic [RW-1:0] cpu_r0,
    input logic [RW-1:0] cpu_pc,
    input logic [IW-1:0] cpu_ir
);
    assert_capture_live_R2: assert property (@(posedge clk_spi) disable iff (!rst_n)
        cap |=> (sh_r0 == $past(cpu_r0)) && (sh_pc == $past(cpu_pc)) && (sh_ir == $past(cpu_ir)));

    assert_ctrl_hold_R3: assert property (@(posedge clk_spi) disable iff (!rst_n)
        cap |=> ctrl_q == $past(ctrl_q));

    assert_ir_shift_R5: assert property (@(posedge clk_spi) disable iff (!rst_n)
        !cap |=> sh_ir == {$past(sh_ir[IW-2:0]), $past(mosi)});

    assert_head_shift_R4: assert property (@(posedge clk_spi) disable iff (!rst_n)
        !cap |=> ctrl_q == {$past(ctrl_q[RW-2:0]), $past(sh_r0[RW-1])});
endmodule

bind dbg_scan_chain dbg_scan_chain_chk #(.RW(RW), .IW(IW)) u_chk (
    .clk_spi (clk_spi), .rst_n (rst_n), .cap (cap_pulse), .mosi (mosi),
    .ctrl_q (ctrl_q), .sh_r0 (sh_r0), .sh_pc (sh_pc), .sh_ir (sh_ir),
    .cpu_r0 (cpu_r0), .cpu_pc (cpu_pc), .cpu_ir (cpu_ir)
);

// File: tb/dbg_scan_chain_tb.sv
`timescale 1ns/1ps
// Bench for the debug scan chain. Both clocks are driven by tasks; the serial
// clock runs at a 5 ns period (200 MHz) while a transfer is in progress.
module dbg_scan_chain_tb;
    localparam int FW = 64;

    logic clk_spi = 1'b0, clk_cpu = 1'b1, rst_n = 1'b0, mosi = 1'b0;
    logic [7:0]  cpu_r0 = '0, cpu_r1 = '0, cpu_r2 = '0, cpu_r3 = '0, cpu_pc = '0;
    logic [15:0] cpu_ir = '0;
    logic        miso, bypass_req, squelch_req, ir_load_en;
    logic [7:0]  sh_r0, sh_r1, sh_r2, sh_r3, sh_pc, ctrl_q;
    logic [15:0] sh_ir;
    logic [3:0]  trigger;

    int total = 0, bad = 0;

    dbg_scan_chain u_dut (
        .clk_spi (clk_spi), .clk_cpu (clk_cpu), .rst_n (rst_n), .mosi (mosi),
        .miso (miso), .cpu_r0 (cpu_r0), .cpu_r1 (cpu_r1), .cpu_r2 (cpu_r2),
        .cpu_r3 (cpu_r3), .cpu_pc (cpu_pc), .cpu_ir (cpu_ir),
        .sh_r0 (sh_r0), .sh_r1 (sh_r1), .sh_r2 (sh_r2), .sh_r3 (sh_r3),
        .sh_pc (sh_pc), .sh_ir (sh_ir), .ctrl_q (ctrl_q),
        .bypass_req (bypass_req), .squelch_req (squelch_req),
        .trigger (trigger), .ir_load_en (ir_load_en)
    );

    // Each entry: live processor state {r0,r1,r2,r3,pc,ir} then the frame sent.
    localparam logic [119:0] VEC [0:3] = '{
        {56'h11223344556677, 64'hA601020304050607},
        {56'h8899AABBCCDDEE, 64'h02F0E1D2C3B4A596},
        {56'hFF00FF00FF8001, 64'h0480402010080102},
        {56'h0123456789ABCD, 64'h50FEDCBA98765432}
    };

    function automatic logic [FW-1:0] par_frame();
        return {ctrl_q, sh_r0, sh_r1, sh_r2, sh_r3, sh_pc, sh_ir};
    endfunction

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One serial clock period: rising edge, then falling edge.
    task automatic spi_clk();
        clk_spi = 1'b1; #2.5;
        clk_spi = 1'b0; #2.5;
    endtask

    // One processor falling edge.
    task automatic cpu_fall();
        clk_cpu = 1'b1; #1;
        clk_cpu = 1'b0; #1;
    endtask

    // Capture then exchange a full frame.
    task automatic xfer(input logic [FW-1:0] din, output logic [FW-1:0] dout);
        cpu_fall();
        spi_clk();
        for (int i = FW - 1; i >= 0; i--) begin
            mosi = din[i]; #1;
            dout[i] = miso;
            spi_clk();
        end
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [FW-1:0] rd, mdl;
        logic [7:0]    prev_ctrl;
        logic [7:0]    c;
        // R1: reset with edges on both clocks
        for (int i = 0; i < 3; i++) begin
            cpu_fall();
            spi_clk();
        end
        rst_n = 1'b1; #1;
        check("R1 reset state", {par_frame()[FW-1:2], miso, ir_load_en}, {62'h0, 1'b0, 1'b1});

        // Table of vectors: capture and frame exchange
        prev_ctrl = 8'h00;
        for (int v = 0; v < 4; v++) begin
            {cpu_r0, cpu_r1, cpu_r2, cpu_r3, cpu_pc, cpu_ir} = VEC[v][119:64];
            xfer(VEC[v][63:0], rd);
            #1;
            check("R2 R3 R4 captured frame on miso", rd, {prev_ctrl, VEC[v][119:64]});
            check("R5 frame replaces chain", par_frame(), VEC[v][63:0]);
            c = VEC[v][63:56];
            check("R6 control fields", {56'h0, trigger, 1'b0, squelch_req, bypass_req, 1'b0},
                  {56'h0, c[7:4], 1'b0, c[2], c[1], 1'b0});
            check("R7 load enable", {63'h0, ir_load_en}, {63'h0, c[1] == c[2]});
            prev_ctrl = c;
        end

        // R8: serial clock with no processor edge shifts
        mdl = VEC[3][63:0];
        mosi = 1'b1; #1;
        spi_clk();
        mdl = {mdl[FW-2:0], 1'b1};
        check("R8 no capture without processor edge", par_frame(), mdl);

        // R9: processor edge while serial clock high is dropped
        mosi = 1'b1; #1;
        clk_spi = 1'b1; #0.5;
        cpu_fall();
        clk_spi = 1'b0; #2.5;
        mosi = 1'b0; #1;
        spi_clk();
        mdl = {mdl[FW-3:0], 2'b10};
        check("R9 late processor edge dropped", par_frame(), mdl);

        // R8: two processor edges give one capture, then shifting resumes
        cpu_fall();
        cpu_fall();
        spi_clk();
        mdl = {mdl[FW-1:FW-8], VEC[3][119:64]};
        check("R2 capture after double edge", par_frame(), mdl);
        mosi = 1'b1; #1;
        spi_clk();
        mdl = {mdl[FW-2:0], 1'b1};
        check("R8 single-shot capture", par_frame(), mdl);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule